// File: doc/BRIEF.md
# I2C Addressed Target with General Call

This block is the target side of an I2C bus interface. It watches the serial clock and data lines through synchronizers, finds start and stop conditions, and shifts in the address byte that follows each start. It answers when that byte matches a programmable 7-bit own address. It can also answer the all-zero general-call address when that is enabled. Once addressed, it either receives bytes into a data output or transmits bytes taken from a data input. It acknowledges received bytes under control of an assert-acknowledge bit.

Each event on the bus becomes a fixed 8-bit status code and raises an interrupt flag. While the flag is set after a byte event, the block holds the clock line low, so the controlling software has time to read the status, supply or collect data and choose the next acknowledge. Software clears the flag with a one-cycle pulse. Both lines are open-drain: the block only ever asks for a line to be pulled low.

Top module: `i2c_target_ctl`

## Requirements
- R1: After reset, status reads 0xF8, the flag is low, and neither the data line nor the clock line is pulled low.
- R2: own_addr[7:1] is the 7-bit own address. With ctl_en and ctl_ack both set, an address byte whose upper seven bits match it is acknowledged. Status becomes 0x60 when the R/W bit (bit 0 of the byte, sent last) is 0, and 0xA8 when it is 1.
- R3: An address byte of 0x00 is acknowledged with status 0x70 only when own_addr[0] is 1. An address byte of 0x01 is never acknowledged as a general call.
- R4: A mismatched address, or any address while ctl_ack or ctl_en is clear, is left unacknowledged, raises no flag, leaves status unchanged and produces no status on the following stop.
- R5: A byte received after an own-address write is presented MSB first on rx_data. Status is 0x80 if ctl_ack was set during that byte, so the byte was acknowledged, and 0x88 if ctl_ack was clear, so the byte was not acknowledged. After 0x88 the block ignores the bus until the next start.
- R6: A byte received after a general call gives 0x90 when acknowledged and 0x98 when not.
- R7: A stop or repeated start while addressed sets status 0xA0 and the flag without holding the clock. A repeated start begins a new address phase.
- R8: In transmit mode the byte on tx_data is captured when the flag is cleared and sent MSB first. If ctl_ack was set at capture, a master ACK gives 0xB8. If ctl_ack was clear at capture, marking the last byte, a master ACK gives 0xC8. A master NACK gives 0xC0.
- R9: After 0xC0 or 0xC8 the data line is released and further clocking raises no flag and changes no status until the next start.
- R10: Every status update sets the flag. After a byte or address event the clock line stays pulled low until flag_clr, and irq equals the flag while ien is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Sensed bus clock line (asynchronous) |
| sda_in | input | 1 | Sensed bus data line (asynchronous) |
| own_addr | input | 8 | Bits 7:1 own address, bit 0 general-call enable |
| ctl_en | input | 1 | Bus enable |
| ctl_ack | input | 1 | Assert acknowledge / not-last-byte control |
| ien | input | 1 | Interrupt enable |
| flag_clr | input | 1 | One-cycle pulse clearing the flag and releasing the clock |
| tx_data | input | 8 | Byte to transmit, captured at flag clear |
| rx_data | output | 8 | Last byte received |
| status | output | 8 | Event code |
| flag | output | 1 | Interrupt flag |
| irq | output | 1 | Flag gated by ien |
| sda_drive_low | output | 1 | 1 pulls the data line low |
| scl_hold_low | output | 1 | 1 pulls the clock line low |

## Verification
The assertions take for granted that the bus master changes the data line only while the clock is low, except when it sends start or stop. They also take for granted that every level is held for several system clocks, so that each level survives the synchronizers and no clock edge is missed. The stimulus keeps a margin of ten system clocks on every level. The master model waits for the clock line to go high before it counts a high phase, so the stretch is honoured. The assertions also rely on software raising flag_clr only to end a service step. The bench pulses it once per event, after it has looked at the status.

// File: rtl/i2ct_pkg.sv
// Shared codes and state type of the I2C target.
// Assumes one status byte per event.
package i2ct_pkg;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(BYTE_W + 1);

    localparam logic [BYTE_W-1:0] ST_NONE     = 8'hF8;
    localparam logic [BYTE_W-1:0] ST_ADDR_WR  = 8'h60;
    localparam logic [BYTE_W-1:0] ST_GC_HIT   = 8'h70;
    localparam logic [BYTE_W-1:0] ST_RX_ACK   = 8'h80;
    localparam logic [BYTE_W-1:0] ST_RX_NACK  = 8'h88;
    localparam logic [BYTE_W-1:0] ST_GRX_ACK  = 8'h90;
    localparam logic [BYTE_W-1:0] ST_GRX_NACK = 8'h98;
    localparam logic [BYTE_W-1:0] ST_END      = 8'hA0;
    localparam logic [BYTE_W-1:0] ST_ADDR_RD  = 8'hA8;
    localparam logic [BYTE_W-1:0] ST_TX_ACK   = 8'hB8;
    localparam logic [BYTE_W-1:0] ST_TX_NACK  = 8'hC0;
    localparam logic [BYTE_W-1:0] ST_TX_LAST  = 8'hC8;

    typedef enum logic [2:0] {
        T_IDLE, T_ADDR, T_RX, T_TX, T_ACK_OUT, T_ACK_IN
    } tgt_state_e;
endpackage

// File: rtl/i2ct_line_sync.sv
// Multi-flop synchronizer for a group of asynchronous lines.
// Assumes STAGES >= 2; lines reset to the released (high) level.
module i2ct_line_sync #(
    parameter int STAGES = 2,
    parameter int LINES  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] raw,
    output logic [LINES-1:0] clean
);
    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [STAGES-1:0] pipe;
        // shift the raw level through the flop chain
        always_ff @(posedge clk) begin
            if (!rst_n) pipe <= '1;
            else        pipe <= {pipe[STAGES-2:0], raw[g]};
        end
        assign clean[g] = pipe[STAGES-1];
    end
endmodule

// File: rtl/i2ct_bus_cond.sv
// Finds start, stop and clock edges on the synchronized bus lines.
// Assumes inputs are already synchronous to clk.
module i2ct_bus_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic start_c,
    output logic stop_c,
    output logic rise_c,
    output logic fall_c
);
    logic scl_p, sda_p;

    // remember the previous line levels
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_p <= scl_s;
            sda_p <= sda_s;
        end
    end

    assign start_c = scl_s & scl_p & sda_p & ~sda_s;
    assign stop_c  = scl_s & scl_p & ~sda_p & sda_s;
    assign rise_c  = scl_s & ~scl_p;
    assign fall_c  = ~scl_s & scl_p;
endmodule

// File: rtl/i2ct_engine.sv
// Target protocol engine: address match, byte shifting, acknowledge,
// status codes, flag and clock stretch.
// Assumes single-cycle condition pulses from i2ct_bus_cond.
module i2ct_engine
    import i2ct_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_c,
    input  logic              stop_c,
    input  logic              rise_c,
    input  logic              fall_c,
    input  logic              sda_s,
    input  logic [BYTE_W-1:0] own_addr,
    input  logic              ctl_en,
    input  logic              ctl_ack,
    input  logic              flag_clr,
    input  logic [BYTE_W-1:0] tx_data,
    output logic [BYTE_W-1:0] rx_data,
    output logic [BYTE_W-1:0] status,
    output logic              flag,
    output logic              sda_drive_low,
    output logic              scl_hold_low
);
    tgt_state_e        st, st_after;
    logic [BYTE_W-1:0] sh, pend, ev_code;
    logic [CNT_W-1:0]  cnt;
    logic              ack_me, gc_mode, last_byte, m_nack;
    logic              ev, ev_hold, addressed, hit_own, hit_gc, full;

    assign addressed = (st == T_RX) || (st == T_TX) ||
                       (st == T_ACK_OUT) || (st == T_ACK_IN);
    assign hit_gc    = (sh == '0) && own_addr[0];
    assign hit_own   = (sh[BYTE_W-1:1] == own_addr[BYTE_W-1:1]) && !hit_gc;
    assign full      = (cnt == CNT_W'(BYTE_W));

    // decide whether this cycle produces a status event
    always_comb begin
        ev      = 1'b0;
        ev_hold = 1'b0;
        ev_code = ST_NONE;
        if (ctl_en) begin
            if ((start_c || stop_c) && addressed) begin
                ev      = 1'b1;
                ev_code = ST_END;
            end else if (fall_c && st == T_ACK_OUT) begin
                ev      = 1'b1;
                ev_hold = 1'b1;
                ev_code = pend;
            end else if (fall_c && st == T_ACK_IN) begin
                ev      = 1'b1;
                ev_hold = 1'b1;
                ev_code = m_nack ? ST_TX_NACK : (last_byte ? ST_TX_LAST : ST_TX_ACK);
            end
        end
    end

    // status, flag and clock-stretch register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status       <= ST_NONE;
            flag         <= 1'b0;
            scl_hold_low <= 1'b0;
        end else if (ev) begin
            status       <= ev_code;
            flag         <= 1'b1;
            scl_hold_low <= ev_hold;
        end else if (flag_clr) begin
            flag         <= 1'b0;
            scl_hold_low <= 1'b0;
        end
    end

    // protocol state machine and shift path
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= T_IDLE;
            st_after  <= T_IDLE;
            sh        <= '1;
            cnt       <= '0;
            ack_me    <= 1'b0;
            gc_mode   <= 1'b0;
            last_byte <= 1'b0;
            m_nack    <= 1'b0;
            pend      <= ST_NONE;
            rx_data   <= '0;
        end else if (!ctl_en) begin
            st <= T_IDLE;
        end else if (start_c) begin
            st  <= T_ADDR;
            cnt <= '0;
        end else if (stop_c) begin
            st <= T_IDLE;
        end else begin
            case (st)
                T_ADDR: begin
                    if (rise_c) begin
                        sh  <= {sh[BYTE_W-2:0], sda_s};
                        cnt <= cnt + 1'b1;
                    end else if (fall_c && full) begin
                        if (ctl_ack && (hit_own || hit_gc)) begin
                            st       <= T_ACK_OUT;
                            ack_me   <= 1'b1;
                            gc_mode  <= hit_gc;
                            pend     <= hit_gc ? ST_GC_HIT : (sh[0] ? ST_ADDR_RD : ST_ADDR_WR);
                            st_after <= (hit_own && sh[0]) ? T_TX : T_RX;
                        end else begin
                            st <= T_IDLE;
                        end
                    end
                end
                T_RX: begin
                    if (rise_c) begin
                        sh  <= {sh[BYTE_W-2:0], sda_s};
                        cnt <= cnt + 1'b1;
                    end else if (fall_c && full) begin
                        rx_data  <= sh;
                        ack_me   <= ctl_ack;
                        pend     <= gc_mode ? (ctl_ack ? ST_GRX_ACK : ST_GRX_NACK)
                                            : (ctl_ack ? ST_RX_ACK  : ST_RX_NACK);
                        st_after <= ctl_ack ? T_RX : T_IDLE;
                        st       <= T_ACK_OUT;
                    end
                end
                T_ACK_OUT: begin
                    if (fall_c) begin
                        st  <= st_after;
                        cnt <= '0;
                        sh  <= '1;
                    end
                end
                T_TX: begin
                    if (flag && flag_clr) begin
                        sh        <= tx_data;
                        last_byte <= !ctl_ack;
                        cnt       <= '0;
                    end else if (rise_c) begin
                        cnt <= cnt + 1'b1;
                    end else if (fall_c) begin
                        if (full) st <= T_ACK_IN;
                        else      sh <= {sh[BYTE_W-2:0], 1'b1};
                    end
                end
                T_ACK_IN: begin
                    if (rise_c) begin
                        m_nack <= sda_s;
                    end else if (fall_c) begin
                        st  <= (m_nack || last_byte) ? T_IDLE : T_TX;
                        sh  <= '1;
                        cnt <= '0;
                    end
                end
                default: st <= st;
            endcase
        end
    end

    assign sda_drive_low = (st == T_ACK_OUT && ack_me) || (st == T_TX && !sh[BYTE_W-1]);
endmodule

// File: rtl/i2c_target_ctl.sv
// Top of the I2C addressed target: synchronizers, condition finder and
// protocol engine. Assumes open-drain pads outside that pull a line low
// when the matching *_low output is 1.
module i2c_target_ctl
    import i2ct_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    input  logic [BYTE_W-1:0] own_addr,
    input  logic              ctl_en,
    input  logic              ctl_ack,
    input  logic              ien,
    input  logic              flag_clr,
    input  logic [BYTE_W-1:0] tx_data,
    output logic [BYTE_W-1:0] rx_data,
    output logic [BYTE_W-1:0] status,
    output logic              flag,
    output logic              irq,
    output logic              sda_drive_low,
    output logic              scl_hold_low
);
    logic [1:0] raw_lines, clean_lines;
    logic       start_c, stop_c, rise_c, fall_c;

    assign raw_lines = {scl_in, sda_in};

    i2ct_line_sync #(.STAGES(SYNC_STAGES), .LINES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .raw(raw_lines), .clean(clean_lines)
    );

    i2ct_bus_cond u_cond (
        .clk(clk), .rst_n(rst_n), .scl_s(clean_lines[1]), .sda_s(clean_lines[0]),
        .start_c(start_c), .stop_c(stop_c), .rise_c(rise_c), .fall_c(fall_c)
    );

    i2ct_engine u_eng (
        .clk(clk), .rst_n(rst_n), .start_c(start_c), .stop_c(stop_c),
        .rise_c(rise_c), .fall_c(fall_c), .sda_s(clean_lines[0]),
        .own_addr(own_addr), .ctl_en(ctl_en), .ctl_ack(ctl_ack),
        .flag_clr(flag_clr), .tx_data(tx_data), .rx_data(rx_data),
        .status(status), .flag(flag), .sda_drive_low(sda_drive_low),
        .scl_hold_low(scl_hold_low)
    );

    assign irq = flag & ien;
endmodule

// File: rtl/i2ct_chk.sv
// Protocol checker for i2c_target_ctl, attached by bind.
// Assumes it sees the top-level ports only.
module i2ct_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       ctl_en,
    input logic       flag_clr,
    input logic       flag,
    input logic [7:0] status,
    input logic       sda_drive_low,
    input logic       scl_hold_low
);
    // R10
    hold_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        scl_hold_low |-> flag);

    // R10
    flag_drop_by_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag) |-> $past(flag_clr));

    // R10
    flag_rise_has_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> status != 8'hF8);

    // R4
    disabled_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_en |=> !sda_drive_low);

    // R9
    nack_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && (status == 8'hC0 || status == 8'hC8)) |-> !sda_drive_low);

    // R7
    end_no_stretch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && status == 8'hA0) |-> !scl_hold_low);

    // R2
    status_code_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        status inside {8'hF8, 8'h60, 8'h70, 8'h80, 8'h88, 8'h90, 8'h98,
                       8'hA0, 8'hA8, 8'hB8, 8'hC0, 8'hC8});
endmodule

bind i2c_target_ctl i2ct_chk u_chk (
    .clk(clk), .rst_n(rst_n), .ctl_en(ctl_en), .flag_clr(flag_clr),
    .flag(flag), .status(status), .sda_drive_low(sda_drive_low),
    .scl_hold_low(scl_hold_low)
);

// File: tb/sim_i2c_target_ctl.sv
module sim_i2c_target_ctl;
    localparam int Q = 10;
    localparam int NV = 9;
    // {own_addr, address byte, ctl_ack, expect ack, expected code}
    localparam logic [25:0] VEC [0:NV-1] = '{
        {8'h84, 8'h84, 1'b1, 1'b1, 8'h60},
        {8'h84, 8'h85, 1'b1, 1'b1, 8'hA8},
        {8'h84, 8'h86, 1'b1, 1'b0, 8'h00},
        {8'h85, 8'h00, 1'b1, 1'b1, 8'h70},
        {8'h84, 8'h00, 1'b1, 1'b0, 8'h00},
        {8'h85, 8'h01, 1'b1, 1'b0, 8'h00},
        {8'hFE, 8'hFE, 1'b1, 1'b1, 8'h60},
        {8'h02, 8'h03, 1'b1, 1'b1, 8'hA8},
        {8'h84, 8'h84, 1'b0, 1'b0, 8'h00}
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic m_scl = 1'b1, m_sda = 1'b1;
    logic [7:0] own_addr = 8'h84, tx_data = 8'hFF;
    logic ctl_en = 1'b1, ctl_ack = 1'b1, ien = 1'b0, flag_clr = 1'b0;
    logic [7:0] rx_data, status;
    logic flag, irq, sda_drive_low, scl_hold_low;
    logic scl_bus, sda_bus;
    int checks = 0, failures = 0;
    logic done = 1'b0;
    logic [7:0] exp_st;

    assign scl_bus = m_scl & ~scl_hold_low;
    assign sda_bus = m_sda & ~sda_drive_low;

    always #10 clk = ~clk;

    i2c_target_ctl u0 (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_bus), .sda_in(sda_bus),
        .own_addr(own_addr), .ctl_en(ctl_en), .ctl_ack(ctl_ack), .ien(ien),
        .flag_clr(flag_clr), .tx_data(tx_data), .rx_data(rx_data),
        .status(status), .flag(flag), .irq(irq),
        .sda_drive_low(sda_drive_low), .scl_hold_low(scl_hold_low)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic waitq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic m_clock(input logic b, output logic s);
        m_sda = b;
        waitq();
        m_scl = 1'b1;
        while (!scl_bus) @(negedge clk);
        waitq();
        s = sda_bus;
        m_scl = 1'b0;
        waitq();
    endtask

    task automatic m_start();
        m_sda = 1'b1;
        waitq();
        m_scl = 1'b1;
        while (!scl_bus) @(negedge clk);
        waitq();
        m_sda = 1'b0;
        waitq();
        m_scl = 1'b0;
        waitq();
    endtask

    task automatic m_stop();
        m_sda = 1'b0;
        waitq();
        m_scl = 1'b1;
        while (!scl_bus) @(negedge clk);
        waitq();
        m_sda = 1'b1;
        waitq();
    endtask

    task automatic m_write(input logic [7:0] d, output logic acked);
        logic s;
        for (int i = 7; i >= 0; i--) m_clock(d[i], s);
        m_clock(1'b1, s);
        acked = ~s;
    endtask

    task automatic m_read(input logic nack_bit, output logic [7:0] d);
        logic s;
        d = '0;
        for (int i = 0; i < 8; i++) begin
            m_clock(1'b1, s);
            d = {d[6:0], s};
        end
        m_clock(nack_bit, s);
    endtask

    task automatic clr();
        @(negedge clk) flag_clr = 1'b1;
        @(negedge clk) flag_clr = 1'b0;
        waitq();
    endtask

    initial begin
        logic a;
        logic [7:0] d;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 status", status, 8'hF8);
        chk("R1 flag", flag, 0);
        chk("R1 sda", sda_drive_low, 0);
        chk("R1 scl", scl_hold_low, 0);

        // table walk: address phase (R2 R3 R4) then stop (R7)
        exp_st = 8'hF8;
        for (int v = 0; v < NV; v++) begin
            own_addr = VEC[v][25:18];
            ctl_ack  = VEC[v][9];
            tx_data  = 8'hFF;
            m_start();
            m_write(VEC[v][17:10], a);
            chk("R2/R3/R4 ack", a, VEC[v][8]);
            if (VEC[v][8]) begin
                exp_st = VEC[v][7:0];
                chk("R2/R3 code", status, exp_st);
                chk("R10 flag", flag, 1);
                chk("R10 hold", scl_hold_low, 1);
                clr();
                chk("R10 hold off", scl_hold_low, 0);
                m_stop();
                exp_st = 8'hA0;
                chk("R7 stop code", status, exp_st);
                chk("R7 flag", flag, 1);
                chk("R7 no hold", scl_hold_low, 0);
                clr();
            end else begin
                chk("R4 no flag", flag, 0);
                m_stop();
                chk("R4 status kept", status, exp_st);
                chk("R4 no flag after stop", flag, 0);
            end
        end
        ctl_ack = 1'b1;

        // R5 data receive with ACK then NACK
        own_addr = 8'h84;
        m_start();
        m_write(8'h84, a);
        clr();
        m_write(8'h5A, a);
        chk("R5 ack seen", a, 1);
        chk("R5 code 80", status, 8'h80);
        chk("R5 rx", rx_data, 8'h5A);
        ctl_ack = 1'b0;
        clr();
        m_write(8'h33, a);
        chk("R5 nack seen", a, 0);
        chk("R5 code 88", status, 8'h88);
        chk("R5 rx2", rx_data, 8'h33);
        clr();
        ctl_ack = 1'b1;
        m_write(8'hC3, a);
        chk("R5 ignored ack", a, 0);
        chk("R5 ignored flag", flag, 0);
        m_stop();
        chk("R5 ignored stop", status, 8'h88);

        // R6 general call data, irq check (R10)
        own_addr = 8'h85;
        ien = 1'b1;
        m_start();
        m_write(8'h00, a);
        chk("R3 gc code", status, 8'h70);
        chk("R10 irq", irq, 1);
        clr();
        chk("R10 irq off", irq, 0);
        m_write(8'h11, a);
        chk("R6 code 90", status, 8'h90);
        chk("R6 rx", rx_data, 8'h11);
        ctl_ack = 1'b0;
        clr();
        m_write(8'h22, a);
        chk("R6 nack", a, 0);
        chk("R6 code 98", status, 8'h98);
        clr();
        ctl_ack = 1'b1;
        ien = 1'b0;
        m_stop();

        // R7 repeated start while addressed
        own_addr = 8'h84;
        m_start();
        m_write(8'h84, a);
        clr();
        m_start();
        chk("R7 rstart code", status, 8'hA0);
        chk("R7 rstart hold", scl_hold_low, 0);
        clr();
        m_write(8'h85, a);
        chk("R7 new addr phase", status, 8'hA8);
        tx_data = 8'hFF;
        clr();
        m_stop();
        clr();

        // R8 transmit: ACK then last byte
        m_start();
        m_write(8'h85, a);
        tx_data = 8'hA5;
        ctl_ack = 1'b1;
        clr();
        m_read(1'b0, d);
        chk("R8 data1", d, 8'hA5);
        chk("R8 code B8", status, 8'hB8);
        chk("R10 tx hold", scl_hold_low, 1);
        tx_data = 8'h3C;
        ctl_ack = 1'b0;
        clr();
        m_read(1'b0, d);
        chk("R8 data2", d, 8'h3C);
        chk("R8 code C8", status, 8'hC8);
        ctl_ack = 1'b1;
        clr();
        m_read(1'b0, d);
        chk("R9 released after C8", d, 8'hFF);
        chk("R9 no flag after C8", flag, 0);
        m_stop();
        chk("R9 status kept C8", status, 8'hC8);

        // R8/R9 master NACK
        m_start();
        m_write(8'h85, a);
        tx_data = 8'h96;
        clr();
        m_read(1'b1, d);
        chk("R8 data3", d, 8'h96);
        chk("R8 code C0", status, 8'hC0);
        tx_data = 8'h00;
        clr();
        m_read(1'b0, d);
        chk("R9 released after C0", d, 8'hFF);
        chk("R9 no flag after C0", flag, 0);
        m_stop();
        chk("R9 status kept C0", status, 8'hC0);

        // R4 bus disabled
        ctl_en = 1'b0;
        m_start();
        m_write(8'h84, a);
        chk("R4 disabled nack", a, 0);
        chk("R4 disabled flag", flag, 0);
        m_stop();
        chk("R4 disabled status", status, 8'hC0);
        ctl_en = 1'b1;

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule